// File: doc/BRIEF.md
# Packet and Burst Framing Source Sequencer

This block sits between a host-side synchronous FIFO and a parallel data channel. It pulls words out of the FIFO and turns them into a connection request followed by packets made of bursts. Each FIFO word carries a data field, a parity field and a 2-bit control field written alongside it by the host. The control field alone tells the sequencer what to do with the word: treat it as a connection header, send it as packet data, close a short burst with it, or end the packet.

The FIFO is read in show-ahead style. The word at the head of the FIFO sits on the input pins while the empty flag is low, and it is consumed on the rising edge in which the active-low read enable is low. The block supplies the FIFO read clock as a copy of its own clock. Bursts are cut automatically at a parameterised maximum length. They also end early on a short-burst marker, when the FIFO runs dry, when the channel withholds burst permission, or when the packet ends. PACKET is raised only together with the first burst word, so an empty packet can never reach the channel.

Top module: `pkt_frame_src`

## Requirements
- R1: `fifo_rd_n` is low in a cycle only when `fifo_empty` is low and the block is either scanning for a header or transferring with `ch_ready` high and no burst gap pending. A word is consumed only on an edge where `fifo_rd_n` is low.
- R2: The control field is {short, avail} = `fifo_ctl[1:0]`. 2'b00 is idle or end of packet, 2'b01 is packet data, 2'b10 is a connection header, and 2'b11 is the last word of a short burst.
- R3: While scanning, every word whose control is not 2'b10 is read and dropped. When a 2'b10 word is read, `ch_data`/`ch_par` show it and `ch_request` is high one cycle later.
- R4: While waiting for a connection answer, no word is read. A `ch_reject` pulse drops `ch_request` on the next cycle and scanning resumes. `ch_connect` high moves the block to transfer, and `ch_reject` wins if both are high.
- R5: In transfer, a word with control 2'b01 or 2'b11 that is read appears on `ch_data`/`ch_par` with `ch_burst` high in the next cycle. `ch_burst` is high in no other cycle.
- R6: After BURST_MAX consecutive burst words, the burst ends: `ch_burst` is low for one cycle, during which nothing is read.
- R7: A 2'b11 word ends the burst after that word, with the same one-cycle gap as R6.
- R8: A cycle in transfer without a read, whether caused by an empty FIFO or by `ch_ready` low, ends the current burst. The next burst word starts a fresh count toward BURST_MAX.
- R9: `ch_packet` rises in the same cycle as the first `ch_burst` of a packet and stays high across burst gaps. It falls in the cycle after a 2'b00 word is read, with `ch_burst` low. A 2'b00 word alone never raises it.
- R10: A 2'b10 word read during transfer drops `ch_request` and `ch_packet` for one cycle, shows the header on `ch_data`, and then raises `ch_request` again while the block waits for a new connection answer.
- R11: After reset, `ch_request`, `ch_packet` and `ch_burst` are low, and `fifo_rd_n` is high while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_rd_clk | output | 1 | Read clock supplied to the FIFO |
| fifo_rd_n | output | 1 | Active-low FIFO read enable |
| fifo_data | input | DATA_W | Head-of-FIFO data word |
| fifo_par | input | PAR_W | Head-of-FIFO parity |
| fifo_ctl | input | 2 | Head-of-FIFO control field {short, avail} |
| fifo_empty | input | 1 | FIFO holds no word |
| ch_connect | input | 1 | Connection accepted by the far end |
| ch_reject | input | 1 | Connection refused by the far end |
| ch_ready | input | 1 | Burst permission from the channel |
| ch_request | output | 1 | Connection request |
| ch_packet | output | 1 | Packet in progress |
| ch_burst | output | 1 | Burst word on the data bus |
| ch_data | output | DATA_W | Channel data bus |
| ch_par | output | PAR_W | Channel parity |

## Verification
`fifo_rd_n` is combinational on the FIFO head and the block state, so it is due in the same cycle as its inputs. The bench compares it shortly after driving those inputs and before the edge. Every channel output is registered once behind the read edge, so the effect of a word consumed at edge N is compared at the falling edge after edge N, and a connect or reject pulse shows at the same point. The reference model advances exactly once per rising edge on the inputs held across it, so each comparison lines up with that single register stage. Burst lengths are gathered from `ch_burst` runs and matched against the expected segmentation.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;

   typedef enum logic [1:0] {
      CTL_IDLE  = 2'b00,
      CTL_PKT   = 2'b01,
      CTL_HDR   = 2'b10,
      CTL_SHORT = 2'b11
   } ctl_e;

   typedef enum logic [1:0] {
      S_SCAN   = 2'd0,
      S_WAIT   = 2'd1,
      S_XFER   = 2'd2,
      S_RELOAD = 2'd3
   } seq_state_e;

endpackage

// File: rtl/pfs_burst_ctr.sv
module pfs_burst_ctr #(
   parameter int BURST_MAX = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic wrap,
   output logic at_last
);
   localparam int CW = (BURST_MAX > 2) ? $clog2(BURST_MAX) : 1;
   localparam logic [CW-1:0] LAST = CW'(BURST_MAX - 1);

   if (BURST_MAX < 2) begin : g_bad_max
      $error("pfs_burst_ctr: BURST_MAX must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!adv || wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign at_last = (cnt_q == LAST);

endmodule

// File: rtl/pfs_out_stage.sv
module pfs_out_stage #(
   parameter int DATA_W       = 32,
   parameter int PAR_W        = 4,
   parameter bit CLR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d_in,
   input  logic [PAR_W-1:0]  p_in,
   output logic [DATA_W-1:0] d_out,
   output logic [PAR_W-1:0]  p_out
);
   localparam int SW = DATA_W + PAR_W;

   if (DATA_W < 1 || PAR_W < 1) begin : g_bad_w
      $error("pfs_out_stage: widths must be positive");
   end

   logic [SW-1:0] stage_q;

   if (CLR_ON_RESET) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q <= '0;
         end else if (load) begin
            stage_q <= {d_in, p_in};
         end
      end
   end else begin : g_nrst
      always_ff @(posedge clk) begin
         if (load) begin
            stage_q <= {d_in, p_in};
         end
      end
   end

   assign d_out = stage_q[SW-1:PAR_W];
   assign p_out = stage_q[PAR_W-1:0];

endmodule

// File: rtl/pkt_frame_src.sv
module pkt_frame_src
   import pkt_frame_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int PAR_W     = 4,
   parameter int BURST_MAX = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              fifo_rd_clk,
   output logic              fifo_rd_n,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic [PAR_W-1:0]  fifo_par,
   input  logic [1:0]        fifo_ctl,
   input  logic              fifo_empty,
   input  logic              ch_connect,
   input  logic              ch_reject,
   input  logic              ch_ready,
   output logic              ch_request,
   output logic              ch_packet,
   output logic              ch_burst,
   output logic [DATA_W-1:0] ch_data,
   output logic [PAR_W-1:0]  ch_par
);

   seq_state_e state_q;
   logic       req_q, pkt_q, bst_q, gap_q;
   logic       rd_en, burst_word, burst_end, hdr_take, at_last;
   ctl_e       ctl;

   assign fifo_rd_clk = clk;
   assign ctl         = ctl_e'(fifo_ctl);

   assign rd_en = !fifo_empty &&
                  ((state_q == S_SCAN) ||
                   ((state_q == S_XFER) && ch_ready && !gap_q));
   assign fifo_rd_n = !rd_en;

   assign burst_word = rd_en && (state_q == S_XFER) &&
                       ((ctl == CTL_PKT) || (ctl == CTL_SHORT));
   assign burst_end  = burst_word && ((ctl == CTL_SHORT) || at_last);
   assign hdr_take   = rd_en && (ctl == CTL_HDR) &&
                       ((state_q == S_SCAN) || (state_q == S_XFER));

   pfs_burst_ctr #(
      .BURST_MAX (BURST_MAX)
   ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (burst_word),
      .wrap    (burst_end),
      .at_last (at_last)
   );

   pfs_out_stage #(
      .DATA_W       (DATA_W),
      .PAR_W        (PAR_W),
      .CLR_ON_RESET (1'b1)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (burst_word || hdr_take),
      .d_in  (fifo_data),
      .p_in  (fifo_par),
      .d_out (ch_data),
      .p_out (ch_par)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_SCAN;
         req_q   <= 1'b0;
         pkt_q   <= 1'b0;
         bst_q   <= 1'b0;
         gap_q   <= 1'b0;
      end else begin
         bst_q <= burst_word;
         gap_q <= burst_end;
         case (state_q)
            S_SCAN: begin
               if (hdr_take) begin
                  req_q   <= 1'b1;
                  state_q <= S_WAIT;
               end
            end
            S_WAIT: begin
               if (ch_reject) begin
                  req_q   <= 1'b0;
                  state_q <= S_SCAN;
               end else if (ch_connect) begin
                  state_q <= S_XFER;
               end
            end
            S_RELOAD: begin
               req_q   <= 1'b1;
               state_q <= S_WAIT;
            end
            default: begin
               if (rd_en) begin
                  case (ctl)
                     CTL_PKT, CTL_SHORT: pkt_q <= 1'b1;
                     CTL_IDLE:           pkt_q <= 1'b0;
                     default: begin
                        req_q   <= 1'b0;
                        pkt_q   <= 1'b0;
                        state_q <= S_RELOAD;
                     end
                  endcase
               end
            end
         endcase
      end
   end

   assign ch_request = req_q;
   assign ch_packet  = pkt_q;
   assign ch_burst   = bst_q;

   // R1
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> fifo_rd_n);

   // R1
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == S_XFER) && !ch_ready) |-> fifo_rd_n);

   // R4
   wait_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WAIT) |-> fifo_rd_n);

   // R9
   burst_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_burst |-> ch_packet);

   // R6
   burst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_burst && gap_q) |=> !ch_burst);

   // R5
   burst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_burst) |-> $past(!fifo_rd_n));

endmodule

// File: tb/pkt_frame_src_tb.sv
`timescale 1ns/100ps
module pkt_frame_src_tb_top;
   localparam int DW = 32;
   localparam int PW = 4;
   localparam int BM = 256;

   typedef struct {
      logic [1:0]    c;
      logic [DW-1:0] d;
   } wd_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_rd_clk, fifo_rd_n;
   logic [DW-1:0] fifo_data = '0;
   logic [PW-1:0] fifo_par = '0;
   logic [1:0] fifo_ctl = 2'b00;
   logic fifo_empty = 1'b1;
   logic ch_connect = 1'b0, ch_reject = 1'b0, ch_ready = 1'b1;
   logic ch_request, ch_packet, ch_burst;
   logic [DW-1:0] ch_data;
   logic [PW-1:0] ch_par;

   always #2 clk = ~clk;

   pkt_frame_src #(.DATA_W(DW), .PAR_W(PW), .BURST_MAX(BM)) dut_i (
      .clk(clk), .rst_n(rst_n), .fifo_rd_clk(fifo_rd_clk), .fifo_rd_n(fifo_rd_n),
      .fifo_data(fifo_data), .fifo_par(fifo_par), .fifo_ctl(fifo_ctl),
      .fifo_empty(fifo_empty), .ch_connect(ch_connect), .ch_reject(ch_reject),
      .ch_ready(ch_ready), .ch_request(ch_request), .ch_packet(ch_packet),
      .ch_burst(ch_burst), .ch_data(ch_data), .ch_par(ch_par));

   wd_t fq[$];
   int  runs[$];
   int  cur_run = 0;
   int  n_chk = 0, n_fail = 0, n_cyc = 0;
   bit  done = 0;

   // reference model state
   int  mst = 0, mcnt = 0;
   bit  mgap = 0, e_req = 0, e_pkt = 0, e_bst = 0;
   logic [DW-1:0] e_data = '0;

   function automatic logic [PW-1:0] par_of(logic [DW-1:0] d);
      logic [PW-1:0] p = '0;
      for (int i = 0; i < DW; i++) p[i % PW] ^= d[i];
      return p;
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, n_cyc);
      end
   endtask

   task automatic push(logic [1:0] c, logic [DW-1:0] d);
      wd_t w;
      w.c = c; w.d = d;
      fq.push_back(w);
   endtask

   task automatic drive_fifo();
      fifo_empty = (fq.size() == 0);
      if (fq.size() != 0) begin
         fifo_ctl  = fq[0].c;
         fifo_data = fq[0].d;
         fifo_par  = par_of(fq[0].d);
      end
   endtask

   task automatic tick();
      bit exp_rd;
      wd_t w;
      drive_fifo();
      #1;
      exp_rd = (fq.size() > 0) && (mst == 0 || (mst == 2 && ch_ready && !mgap));
      chk(fifo_rd_n === !exp_rd, "R1 read enable", longint'(fifo_rd_n), longint'(!exp_rd));
      @(posedge clk);
      e_bst = 0;
      if (exp_rd) w = fq.pop_front();
      case (mst)
         0: if (exp_rd && w.c == 2'b10) begin e_data = w.d; e_req = 1; mst = 1; end
         1: if (ch_reject) begin e_req = 0; mst = 0; end
            else if (ch_connect) mst = 2;
         3: begin e_req = 1; mst = 1; end
         default: begin
            mgap = 0;
            if (exp_rd) begin
               if (w.c[0]) begin
                  e_bst = 1; e_pkt = 1; e_data = w.d;
                  if (w.c == 2'b11 || mcnt == BM - 1) begin mcnt = 0; mgap = 1; end
                  else mcnt++;
               end else if (w.c == 2'b00) begin
                  e_pkt = 0; mcnt = 0;
               end else begin
                  e_req = 0; e_pkt = 0; e_data = w.d; mcnt = 0; mst = 3;
               end
            end else mcnt = 0;
         end
      endcase
      if (!e_bst) mcnt = (mst == 2 && exp_rd && w.c[0]) ? mcnt : 0;
      @(negedge clk);
      n_cyc++;
      chk(ch_request === e_req, "R3 request", longint'(ch_request), longint'(e_req));
      chk(ch_burst === e_bst, "R5 burst", longint'(ch_burst), longint'(e_bst));
      chk(ch_packet === e_pkt, "R9 packet", longint'(ch_packet), longint'(e_pkt));
      if (e_bst || e_req)
         chk(ch_data === e_data && ch_par === par_of(e_data), "R5 data",
             longint'(ch_data), longint'(e_data));
      if (ch_burst) cur_run++;
      else if (cur_run > 0) begin runs.push_back(cur_run); cur_run = 0; end
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      bit low_seen, pkt_seen;
      int sum;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!ch_request && !ch_packet && !ch_burst, "R11 flags",
          longint'({ch_request, ch_packet, ch_burst}), 0);
      chk(fifo_rd_n === 1'b1, "R11 read enable", longint'(fifo_rd_n), 1);
      rst_n = 1'b1;

      // R3 scanning drops non-header words
      push(2'b00, 32'h0000_0011);
      push(2'b01, 32'h0000_0022);
      push(2'b10, 32'hA000_0001);
      repeat (4) tick();
      chk(ch_request && ch_data == 32'hA000_0001, "R3 header A",
          longint'(ch_data), longint'(32'hA000_0001));
      // R4 no read while waiting, reject resumes scan
      push(2'b10, 32'hB000_0002);
      repeat (2) tick();
      chk(fq.size() == 1, "R4 held header", fq.size(), 1);
      ch_reject = 1'b1; ch_connect = 1'b1;
      tick();
      ch_reject = 1'b0; ch_connect = 1'b0;
      chk(!ch_request, "R4 reject", longint'(ch_request), 0);
      repeat (2) tick();
      chk(ch_request && ch_data == 32'hB000_0002, "R3 header B",
          longint'(ch_data), longint'(32'hB000_0002));
      ch_connect = 1'b1;
      tick();
      ch_connect = 1'b0;

      // R7 R6 short burst then automatic segmentation
      runs.delete();
      for (int i = 0; i < 3; i++) push(2'b01, 32'h1000_0000 + i);
      push(2'b11, 32'h1000_00FF);
      for (int i = 0; i < 300; i++) push(2'b01, 32'h2000_0000 + i);
      push(2'b00, 32'h0);
      while (fq.size() > 0) tick();
      repeat (3) tick();
      chk(runs.size() == 3, "R6 burst count", runs.size(), 3);
      if (runs.size() == 3) begin
         chk(runs[0] == 4, "R7 short burst length", runs[0], 4);
         chk(runs[0] == 4, "R2 code 11 closes burst", runs[0], 4);
         chk(runs[1] == BM, "R6 full burst length", runs[1], BM);
         chk(runs[2] == 300 - BM, "R6 remainder length", runs[2], 300 - BM);
      end
      chk(!ch_packet, "R9 packet closed", longint'(ch_packet), 0);

      // R8 FIFO starvation and withheld permission
      runs.delete();
      for (int i = 0; i < 5; i++) push(2'b01, 32'h3000_0000 + i);
      repeat (8) tick();
      for (int i = 0; i < 3; i++) push(2'b01, 32'h3100_0000 + i);
      repeat (4) tick();
      chk(runs.size() == 2 && runs[0] == 5 && runs[1] == 3, "R8 dry split",
          runs.size(), 2);
      runs.delete();
      for (int i = 0; i < 10; i++) push(2'b01, 32'h3200_0000 + i);
      repeat (3) tick();
      ch_ready = 1'b0;
      repeat (3) tick();
      ch_ready = 1'b1;
      repeat (10) tick();
      push(2'b00, 32'h0);
      repeat (3) tick();
      sum = 0;
      foreach (runs[i]) sum += runs[i];
      chk(runs.size() == 2 && sum == 10, "R8 permission split", runs.size(), 2);

      // R9 idle word alone raises no packet
      pkt_seen = 0;
      push(2'b00, 32'h0);
      repeat (3) begin tick(); pkt_seen |= ch_packet; end
      chk(!pkt_seen, "R9 empty packet", longint'(pkt_seen), 0);

      // R10 header inside transfer
      low_seen = 0;
      push(2'b01, 32'h4000_0001);
      push(2'b01, 32'h4000_0002);
      push(2'b10, 32'hC000_0003);
      repeat (5) begin tick(); if (!ch_request) low_seen = 1; end
      chk(low_seen, "R10 request gap", longint'(low_seen), 1);
      chk(ch_request && ch_data == 32'hC000_0003 && !ch_packet, "R10 new header",
          longint'(ch_data), longint'(32'hC000_0003));
      ch_reject = 1'b1;
      tick();
      ch_reject = 1'b0;
      repeat (2) tick();

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule